// File: doc/BRIEF.md
# Chained Converter Serial Output Shifter

This block is the digital serial side of a sampling converter that can be chained with identical devices on one serial line. Each device's output feeds the next device's serial input, and the last device feeds the host. A rising edge on the convert-start pin begins a conversion. The device enters chained operation only when the serial input and the serial clock are both low at that edge. Otherwise the edge is ignored.

The conversion phase is a fixed number of system clock cycles, and serial clock activity does not affect it. When the phase ends, the 16-bit result from the `result_i` test port is loaded into a shift register and its MSB appears on the serial output. Each falling serial clock edge moves the output to the next lower bit. On the same edge, the value that the serial input held just before the edge enters the register's LSB. So once its own word has gone out, the device forwards the upstream word, MSB first, with no gap.

Convert-start, serial clock and serial input are asynchronous pins. Each passes through two synchronising flip-flops, and edges are detected on the synchronised levels. A falling convert-start returns the device to acquisition and forces the output low.

Top module: `chain_adc_shifter`

## Requirements
- R1: After synchronous reset, `sdo_o` is low and the device is in acquisition.
- R2: A conversion starts only on a rising `convst_i` edge at which `sdi_i` and `sclk_i` are both low. A rise with either of them high starts nothing, and `sdo_o` stays low.
- R3: The conversion lasts CONV_CYCLES clock cycles. With two synchroniser stages, the result MSB appears on `sdo_o` exactly CONV_CYCLES+3 clock cycles after `convst_i` rises at the pin, and `sdo_o` is low before that.
- R4: Rising and falling `sclk_i` edges during the conversion phase have no effect on the word that is later shifted out.
- R5: After the load, `sdo_o` shows bit 15 of the result. Each falling `sclk_i` edge moves it one bit lower, and rising edges change nothing.
- R6: On each falling `sclk_i` edge, the `sdi_i` level held before that edge enters the register LSB. After the 16th fall, `sdo_o` carries the upstream word MSB first, with no gap between the two words.
- R7: With `sdi_i` held low, `sdo_o` is low after the 16th falling `sclk_i` edge and stays low on later falls.
- R8: A falling `convst_i` edge in any phase returns the device to acquisition. Within 4 clock cycles `sdo_o` is low, and the register contents are discarded.
- R9: `result_i` is captured in the cycle the conversion ends. Later changes to it do not affect `sdo_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| convst_i | input | 1 | Convert-start pin, asynchronous |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdi_i | input | 1 | Serial data from the upstream device, asynchronous |
| result_i | input | WORD_W | Conversion result supplied by the test environment |
| sdo_o | output | 1 | Serial data out, registered |

## Verification
On every cycle, the assertions check these properties:
- The register holds still through the conversion phase and between clock falls.
- A falling convert-start forces acquisition and a low output.
- Mode entry is refused when the serial input or serial clock is high.
- The word loaded at the end of conversion matches the result port.
- The conversion counter stays bounded.

Only the bench scenarios can show the exact start latency, the bit order across the own and upstream words, and the low tail on a first-in-chain device. They also cover aborts part-way through a shift and the effect of serial clock toggling during conversion on the bits finally read.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;
  typedef enum logic [1:0] {
    PH_ACQ   = 2'd0,
    PH_CONV  = 2'd1,
    PH_SHIFT = 2'd2
  } phase_e;
endpackage

// File: rtl/cas_sync_edge.sv
module cas_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/cas_conv_timer.sv
module cas_conv_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(cnt_q) < CYCLES));

  // R3
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/cas_shift_reg.sv
module cas_shift_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] word_i,
  input  logic         ser_i,
  output logic         msb_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) word_q <= '0;
    else if (load_i)    word_q <= word_i;
    else if (shift_i)   word_q <= {word_q[W-2:0], ser_i};
  end

  assign msb_o = word_q[W-1];

  // R6
  shift_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !load_i && !clear_i) |=> (word_q[0] == $past(ser_i)));
endmodule

// File: rtl/chain_adc_shifter.sv
module chain_adc_shifter
  import chain_adc_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              convst_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] result_i,
  output logic              sdo_o
);
  phase_e st_q;
  logic cv_lvl, cv_prev, ck_lvl, ck_prev, sd_lvl, sd_prev;
  logic cv_rise, cv_fall, ck_fall;
  logic conv_done, do_load, do_shift;

  cas_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_cv (
    .clk(clk), .rst(rst), .pin_i(convst_i), .lvl_o(cv_lvl), .prev_o(cv_prev));
  cas_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_ck (
    .clk(clk), .rst(rst), .pin_i(sclk_i), .lvl_o(ck_lvl), .prev_o(ck_prev));
  cas_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_sd (
    .clk(clk), .rst(rst), .pin_i(sdi_i), .lvl_o(sd_lvl), .prev_o(sd_prev));

  assign cv_rise = cv_lvl && !cv_prev;
  assign cv_fall = !cv_lvl && cv_prev;
  assign ck_fall = !ck_lvl && ck_prev;

  cas_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run_i(st_q == PH_CONV), .done_o(conv_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= PH_ACQ;
    end else begin
      case (st_q)
        PH_ACQ:   if (cv_rise && !sd_lvl && !ck_lvl) st_q <= PH_CONV;
        PH_CONV:  if (cv_fall) st_q <= PH_ACQ;
                  else if (conv_done) st_q <= PH_SHIFT;
        PH_SHIFT: if (cv_fall) st_q <= PH_ACQ;
        default:  st_q <= PH_ACQ;
      endcase
    end
  end

  assign do_load  = (st_q == PH_CONV) && conv_done && !cv_fall;
  assign do_shift = (st_q == PH_SHIFT) && ck_fall && !cv_fall;

  // sd_prev is aligned with ck_prev: the level held just before the fall
  cas_shift_reg #(.W(WORD_W)) u_shreg (
    .clk(clk), .rst(rst), .clear_i(cv_fall), .load_i(do_load),
    .shift_i(do_shift), .word_i(result_i), .ser_i(sd_prev), .msb_o(sdo_o));

  // R2
  mode_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_ACQ && (sd_lvl || ck_lvl)) |=> (st_q == PH_ACQ));

  // R4
  conv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_CONV && !conv_done && !cv_fall) |=> !sdo_o);

  // R5
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_SHIFT && !ck_fall && !cv_fall) |=> $stable(sdo_o));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    cv_fall |=> (st_q == PH_ACQ && !sdo_o));

  // R9
  load_msb_chk: assert property (@(posedge clk) disable iff (rst)
    do_load |=> (st_q == PH_SHIFT && sdo_o == $past(result_i[WORD_W-1])));

  // R1
  acq_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_ACQ && $past(st_q) == PH_ACQ) |-> !sdo_o);
endmodule

// File: tb/chain_adc_shifter_test.sv
module chain_adc_shifter_test;
  localparam int W = 16;
  localparam int C = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic convst = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [W-1:0] result = '0;
  logic sdo;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chain_adc_shifter #(.WORD_W(W), .CONV_CYCLES(C), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .convst_i(convst), .sclk_i(sclk), .sdi_i(sdi),
    .result_i(result), .sdo_o(sdo));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sdo=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input int k, input logic [W-1:0] own,
                                   input logic [W-1:0] up);
    if (k < W)          return own[W-1-k];
    else if (k < 2 * W) return up[2*W-1-k];
    else                return 1'b0;
  endfunction

  // full chained read; abort_at < 2W+1 drops CONVST after that many falls
  task automatic run_chain(input logic [W-1:0] own, input logic [W-1:0] up,
                           input bit toggle, input int abort_at);
    result = own; sdi = 1'b0; sclk = 1'b0;
    tick(4);
    convst = 1'b1;
    if (toggle) begin
      tick(3);
      for (int i = 0; i < C / 8; i++) begin
        sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
      end
      tick(C + 1 - 3 - 4 * (C / 8));
    end else begin
      tick(C + 1);
    end
    check("R3", sdo, 1'b0);
    tick(2);
    for (int k = 0; k <= 2 * W; k++) begin
      check((k < W) ? "R5" : ((up == '0) ? "R7" : "R6"), sdo, exp_bit(k, own, up));
      if (k == 0) begin
        result = ~own;
        if (toggle) check("R4", sdo, own[W-1]);
        else        check("R9", sdo, own[W-1]);
      end
      if (k == abort_at) begin
        convst = 1'b0;
        tick(4);
        check("R8", sdo, 1'b0);
        return;
      end
      if (k == 2 * W) break;
      sclk = 1'b1;
      sdi = (k < W) ? up[W-1-k] : 1'b0;
      tick(4);
      if (k < W) check("R5", sdo, exp_bit(k, own, up));
      sclk = 1'b0;
      tick(4);
    end
    convst = 1'b0;
    sdi = 1'b0;
    tick(4);
    check("R8", sdo, 1'b0);
  endtask

  task automatic refused_start(input logic sd, input logic sk);
    result = 16'hFFFF; sdi = sd; sclk = sk;
    tick(4);
    convst = 1'b1;
    tick(C + 10);
    check("R2", sdo, 1'b0);
    sclk = 1'b0; tick(2); sclk = 1'b1; tick(4);
    check("R2", sdo, 1'b0);
    convst = 1'b0; sdi = 1'b0; sclk = 1'b0;
    tick(4);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    check("R1", sdo, 1'b0);
    run_chain(16'hA5C3, 16'h0000, 1'b0, 99);
    run_chain(16'hFFFF, 16'h8001, 1'b0, 99);
    run_chain(16'h0001, 16'hFFFF, 1'b1, 99);
    run_chain(16'h8000, 16'h1234, 1'b1, 99);
    for (int i = 0; i < W; i++)
      run_chain(16'(1 << i), ~16'(1 << i), i[0], 99);
    refused_start(1'b1, 1'b0);
    refused_start(1'b0, 1'b1);
    run_chain(16'hC0DE, 16'h5A5A, 1'b0, 5);
    run_chain(16'h7E81, 16'h3C3C, 1'b0, 20);
    run_chain(16'h9999, 16'h6666, 1'b0, 99);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule